// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank Controller

This block manages a bank of 32 general-purpose pins behind a 32-bit register port. Each pin has a direction bit and an output data bit. Input pins are sampled through a two-stage synchroniser. Software can change output bits one at a time without a read-modify-write, because separate set and clear registers act only on the bits written as ones.

Every pin can flag an event on a rising edge, a falling edge, a low level or a high level, in any mix. Detected events are latched in one shared status word. Writing ones to a status address clears the matching bits. Two interrupt outputs read from that status, and each output has its own enable mask. The two masks are also changed through set and clear registers. The block is meant for a system bus that issues single-cycle write strobes and reads whose data returns one cycle later.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction register (0x134) reads all ones, so every pin is an input. The output data, all four detect registers, both enable masks and the status all read zero. Both interrupt outputs and every `pinDrive` bit are low.
- R2: Writing 0x13C replaces the output data. Writing 0x194 sets the output bits where the written word has ones. Writing 0x190 clears those bits. In both the set and clear cases, zero bits leave the output unchanged. `pinOut` always equals the output data, and reading 0x13C returns it.
- R3: In the direction register at 0x134, bit value 1 makes the pin an input and bit value 0 makes it a driven output. `pinDrive[i]` is the inverse of bit i.
- R4: Reading 0x138 returns the pin inputs after two synchronising flops. A level applied to `pinIn` becomes readable by the third rising clock edge after the change.
- R5: A set bit in 0x148 (rising) or 0x14C (falling) latches the pin's status bit when the synchronised sample changes in that direction. With both bits set, the pin detects both edges. An edge event stays latched after the pin returns to its old level.
- R6: A set bit in 0x140 (low level) or 0x144 (high level) sets the status bit on every cycle that the synchronised pin is at that level. Clearing the bit therefore has no lasting effect while the level persists.
- R7: Writing to 0x02C or 0x030 clears the status bits where the word has ones and leaves the other bits alone. A new event in the same cycle as the clear wins.
- R8: Reading 0x024 or 0x028 returns the unmasked status. Reading 0x02C returns the status ANDed with mask 0, and reading 0x030 returns it ANDed with mask 1.
- R9: Writing ones to 0x034 (mask 0) or 0x038 (mask 1) sets enable bits. Writing ones to 0x03C (mask 0) or 0x040 (mask 1) clears them. Reading the set or clear address of a line returns that line's mask.
- R10: `irqLine0` is the OR over all bits of status AND mask 0, and `irqLine1` is the same for mask 1. Each follows the register state in the same cycle, with no added delay.
- R11: Offset 0x000 reads the revision, with the major number in bits 7:4 and the minor number in bits 3:0 (defaults 2 and 1, giving 0x21). Unmapped offsets read zero, and writes to them change nothing.
- R12: `rdData` updates one clock edge after a cycle with `rdEn` high, and it holds its value in cycles without `rdEn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register at `addr` |
| rdEn | input | 1 | Read strobe; data is returned on the next edge |
| addr | input | 9 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| pinIn | input | 32 | Asynchronous pin inputs |
| pinOut | output | 32 | Output data for the pins |
| pinDrive | output | 32 | Per-pin output enable (1 = driven) |
| irqLine0 | output | 1 | Interrupt through mask 0 |
| irqLine1 | output | 1 | Interrupt through mask 1 |

## Verification
The bench targets level events that persist through a clear. A design that let the clear win would report the bit as gone while the pin is still low. It checks edge events after the pin has returned to its old level, which catches a design that recomputes status instead of latching it. Set and clear writes mix ones and zeros, so an implementation that writes the whole word, or touches the zero bits, gives wrong output data. Random detect masks, enables and pin transitions are used to compare the raw and masked status and both interrupt lines, which exposes a swapped mask or a missing edge direction.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 9;
  localparam int NLINES = 2;

  localparam logic [ADDR_W-1:0] OFS_REV     = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_RAW0    = 9'h024;
  localparam logic [ADDR_W-1:0] OFS_RAW1    = 9'h028;
  localparam logic [ADDR_W-1:0] OFS_STAT0   = 9'h02C;
  localparam logic [ADDR_W-1:0] OFS_STAT1   = 9'h030;
  localparam logic [ADDR_W-1:0] OFS_ENSET0  = 9'h034;
  localparam logic [ADDR_W-1:0] OFS_ENSET1  = 9'h038;
  localparam logic [ADDR_W-1:0] OFS_ENCLR0  = 9'h03C;
  localparam logic [ADDR_W-1:0] OFS_ENCLR1  = 9'h040;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 9'h134;
  localparam logic [ADDR_W-1:0] OFS_IN      = 9'h138;
  localparam logic [ADDR_W-1:0] OFS_OUT     = 9'h13C;
  localparam logic [ADDR_W-1:0] OFS_LOW     = 9'h140;
  localparam logic [ADDR_W-1:0] OFS_HIGH    = 9'h144;
  localparam logic [ADDR_W-1:0] OFS_RISE    = 9'h148;
  localparam logic [ADDR_W-1:0] OFS_FALL    = 9'h14C;
  localparam logic [ADDR_W-1:0] OFS_OUTCLR  = 9'h190;
  localparam logic [ADDR_W-1:0] OFS_OUTSET  = 9'h194;

  typedef enum logic [3:0] {
    RD_ZERO, RD_REV, RD_RAW, RD_MASK0, RD_MASK1, RD_EN0, RD_EN1,
    RD_DIR, RD_IN, RD_OUT, RD_LOW, RD_HIGH, RD_RISE, RD_FALL
  } rdSel_e;

  typedef struct packed {
    logic              wrDir;
    logic              wrOut;
    logic              setOut;
    logic              clrOut;
    logic              wrLow;
    logic              wrHigh;
    logic              wrRise;
    logic              wrFall;
    logic              clrStat;
    logic [NLINES-1:0] setEn;
    logic [NLINES-1:0] clrEn;
    logic              rdEn;
    rdSel_e            rdSel;
  } strobes_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          strb
);
  always_comb begin
    strb = '0;
    strb.rdEn = rdEn;
    if (wrEn) begin
      unique case (addr)
        OFS_DIR:    strb.wrDir    = 1'b1;
        OFS_OUT:    strb.wrOut    = 1'b1;
        OFS_OUTSET: strb.setOut   = 1'b1;
        OFS_OUTCLR: strb.clrOut   = 1'b1;
        OFS_LOW:    strb.wrLow    = 1'b1;
        OFS_HIGH:   strb.wrHigh   = 1'b1;
        OFS_RISE:   strb.wrRise   = 1'b1;
        OFS_FALL:   strb.wrFall   = 1'b1;
        OFS_STAT0, OFS_STAT1: strb.clrStat = 1'b1;
        OFS_ENSET0: strb.setEn[0] = 1'b1;
        OFS_ENSET1: strb.setEn[1] = 1'b1;
        OFS_ENCLR0: strb.clrEn[0] = 1'b1;
        OFS_ENCLR1: strb.clrEn[1] = 1'b1;
        default: ;
      endcase
    end
    unique case (addr)
      OFS_REV:               strb.rdSel = RD_REV;
      OFS_RAW0, OFS_RAW1:    strb.rdSel = RD_RAW;
      OFS_STAT0:             strb.rdSel = RD_MASK0;
      OFS_STAT1:             strb.rdSel = RD_MASK1;
      OFS_ENSET0, OFS_ENCLR0: strb.rdSel = RD_EN0;
      OFS_ENSET1, OFS_ENCLR1: strb.rdSel = RD_EN1;
      OFS_DIR:               strb.rdSel = RD_DIR;
      OFS_IN:                strb.rdSel = RD_IN;
      OFS_OUT:               strb.rdSel = RD_OUT;
      OFS_LOW:               strb.rdSel = RD_LOW;
      OFS_HIGH:              strb.rdSel = RD_HIGH;
      OFS_RISE:              strb.rdSel = RD_RISE;
      OFS_FALL:              strb.rdSel = RD_FALL;
      default:               strb.rdSel = RD_ZERO;
    endcase
  end

  // R11: a single write touches at most one register
  a_r11_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrDir, strb.wrOut, strb.setOut, strb.clrOut, strb.wrLow,
              strb.wrHigh, strb.wrRise, strb.wrFall, strb.clrStat,
              strb.setEn, strb.clrEn}));
  a_r11_no_write_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strb.wrDir || strb.clrStat || strb.setOut || strb.clrOut));
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int         NPINS     = 32,
  parameter logic [3:0] REV_MAJOR = 4'd2,
  parameter logic [3:0] REV_MINOR = 4'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [NPINS-1:0]  wrData,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinDrive,
  output logic [NLINES-1:0] irq,
  output logic [NPINS-1:0]  rdData
);
  localparam int REV_PAD = NPINS - 8;

  logic [NPINS-1:0] dirQ, outQ, lowQ, highQ, riseQ, fallQ, statQ;
  logic [NPINS-1:0] syncA, syncB, prevQ, rdQ;
  logic [NPINS-1:0] riseEvt, fallEvt, lvlEvt, evt, clrMask, rdMux;
  logic [NLINES-1:0][NPINS-1:0] enBus;

  // configuration and output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ  <= '1;
      outQ  <= '0;
      lowQ  <= '0;
      highQ <= '0;
      riseQ <= '0;
      fallQ <= '0;
    end else begin
      if (strb.wrDir)       dirQ <= wrData;
      if (strb.wrOut)       outQ <= wrData;
      else if (strb.setOut) outQ <= outQ | wrData;
      else if (strb.clrOut) outQ <= outQ & ~wrData;
      if (strb.wrLow)  lowQ  <= wrData;
      if (strb.wrHigh) highQ <= wrData;
      if (strb.wrRise) riseQ <= wrData;
      if (strb.wrFall) fallQ <= wrData;
    end
  end

  // two-flop synchroniser plus previous sample for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  assign riseEvt = syncB & ~prevQ & riseQ;
  assign fallEvt = ~syncB & prevQ & fallQ;
  assign lvlEvt  = (~syncB & lowQ) | (syncB & highQ);
  assign evt     = riseEvt | fallEvt | lvlEvt;
  assign clrMask = strb.clrStat ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~clrMask) | evt;
  end

  // one enable mask and one interrupt output per line
  for (genvar l = 0; l < NLINES; l++) begin : g_line
    logic [NPINS-1:0] enQ;
    always_ff @(posedge clk) begin
      if (!rstN)              enQ <= '0;
      else if (strb.setEn[l]) enQ <= enQ | wrData;
      else if (strb.clrEn[l]) enQ <= enQ & ~wrData;
    end
    assign enBus[l] = enQ;
    assign irq[l]   = |(statQ & enQ);
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_REV:   rdMux = {{REV_PAD{1'b0}}, REV_MAJOR, REV_MINOR};
      RD_RAW:   rdMux = statQ;
      RD_MASK0: rdMux = statQ & enBus[0];
      RD_MASK1: rdMux = statQ & enBus[1];
      RD_EN0:   rdMux = enBus[0];
      RD_EN1:   rdMux = enBus[1];
      RD_DIR:   rdMux = dirQ;
      RD_IN:    rdMux = syncB;
      RD_OUT:   rdMux = outQ;
      RD_LOW:   rdMux = lowQ;
      RD_HIGH:  rdMux = highQ;
      RD_RISE:  rdMux = riseQ;
      RD_FALL:  rdMux = fallQ;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdQ <= '0;
    else if (strb.rdEn) rdQ <= rdMux;
  end

  assign rdData   = rdQ;
  assign pinOut   = outQ;
  assign pinDrive = ~dirQ;

  // R2: written ones take effect and survive into the next cycle
  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rstN)
    strb.setOut |=> ((outQ & $past(wrData)) == $past(wrData)));
  a_r2_clear_sticks: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrOut |=> ((outQ & $past(wrData)) == '0));
  // R6: an active level always leaves its status bit set
  a_r6_level_holds: assert property (@(posedge clk) disable iff (!rstN)
    (lvlEvt != '0) |=> ((statQ & $past(lvlEvt)) == $past(lvlEvt)));
  // R7: cleared bits are gone unless a fresh event arrived
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStat |=> ((statQ & $past(wrData) & ~$past(evt)) == '0));
  // R10: an interrupt needs a latched event behind it
  a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rstN)
    (irq != '0) |-> (statQ != '0));
  // R12: read data only moves after a read strobe
  a_r12_read_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdQ));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int         NPINS     = 32,
  parameter logic [3:0] REV_MAJOR = 4'd2,
  parameter logic [3:0] REV_MINOR = 4'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wrData,
  output logic [NPINS-1:0]  rdData,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinDrive,
  output logic              irqLine0,
  output logic              irqLine1
);
  strobes_t          strb;
  logic [NLINES-1:0] irq;

  gpio_bank_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strb(strb)
  );

  gpio_bank_dp #(.NPINS(NPINS), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .pinIn(pinIn),
    .pinOut(pinOut), .pinDrive(pinDrive), .irq(irq), .rdData(rdData)
  );

  assign irqLine0 = irq[0];
  assign irqLine1 = irq[1];
endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, pinOut, pinDrive;
  logic [31:0] pinIn = '0;
  logic        irqLine0, irqLine1;
  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinDrive(pinDrive), .irqLine0(irqLine0), .irqLine1(irqLine1)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic setPins(logic [31:0] p);
    @(negedge clk);
    pinIn = p;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] lvlOf(logic [31:0] p, logic [31:0] lo, logic [31:0] hi);
    return (~p & lo) | (p & hi);
  endfunction

  function automatic logic [31:0] edgeOf(logic [31:0] o, logic [31:0] n,
                                         logic [31:0] r, logic [31:0] f);
    return (~o & n & r) | (o & ~n & f);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] v, outM;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(9'h134, v); chk("R1 dir reset", v, 32'hFFFF_FFFF);
    rd(9'h13C, v); chk("R1 out reset", v, 32'h0);
    rd(9'h024, v); chk("R1 status reset", v, 32'h0);
    rd(9'h034, v); chk("R1 enable0 reset", v, 32'h0);
    rd(9'h148, v); chk("R1 rise reset", v, 32'h0);
    chk("R1 irq reset", {30'd0, irqLine1, irqLine0}, 32'h0);
    chk("R1 drive reset", pinDrive, 32'h0);

    // R11 revision and unmapped offsets
    rd(9'h000, v); chk("R11 revision", v, 32'h21);
    wr(9'h100, 32'hFFFF_FFFF);
    rd(9'h100, v); chk("R11 unmapped read", v, 32'h0);
    rd(9'h134, v); chk("R11 unmapped write ignored", v, 32'hFFFF_FFFF);

    // R12 read data holds without a strobe
    @(negedge clk); @(negedge clk);
    chk("R12 read holds", rdData, 32'hFFFF_FFFF);

    // R2 output data
    wr(9'h13C, 32'h0000_F0F0);
    wr(9'h194, 32'h0000_000F);
    rd(9'h13C, v); chk("R2 set bits", v, 32'h0000_F0FF);
    wr(9'h190, 32'h0000_00F0);
    rd(9'h13C, v); chk("R2 clear bits", v, 32'h0000_F00F);
    chk("R2 pinOut", pinOut, 32'h0000_F00F);
    outM = 32'h0000_F00F;

    // R3 direction
    wr(9'h134, 32'hFFFF_0000);
    chk("R3 drive", pinDrive, 32'h0000_FFFF);

    // R4 input sampling
    setPins(32'hA5A5_0000);
    rd(9'h138, v); chk("R4 input", v, 32'hA5A5_0000);
    setPins(32'h0);

    // R6 level-low on pin 3
    wr(9'h140, 32'h0000_0008);
    repeat (3) @(negedge clk);
    rd(9'h024, v); chk("R6 low level sets", v, 32'h8);
    wr(9'h02C, 32'h0000_0008);
    rd(9'h024, v); chk("R6 clear ineffective while low", v, 32'h8);
    setPins(32'h0000_0008);
    wr(9'h02C, 32'h0000_0008);
    rd(9'h024, v); chk("R6 clear after level gone", v, 32'h0);
    wr(9'h140, 32'h0);
    wr(9'h144, 32'h0000_0001);
    setPins(32'h0000_0009);
    rd(9'h028, v); chk("R6 high level sets", v, 32'h1);
    wr(9'h144, 32'h0);
    wr(9'h02C, 32'hFFFF_FFFF);
    setPins(32'h0);

    // R5 edges
    wr(9'h148, 32'h0000_0060);
    wr(9'h14C, 32'h0000_0040);
    setPins(32'h0000_0020);
    setPins(32'h0000_0000);
    rd(9'h024, v); chk("R5 rising latched after return", v, 32'h20);
    wr(9'h030, 32'h0000_0020);
    rd(9'h024, v); chk("R7 clear via second address", v, 32'h0);
    setPins(32'h0000_0040);
    wr(9'h02C, 32'h0000_0040);
    rd(9'h024, v); chk("R7 clear edge", v, 32'h0);
    setPins(32'h0000_0000);
    rd(9'h024, v); chk("R5 both-edge falling", v, 32'h40);
    wr(9'h02C, 32'h0000_0000);
    rd(9'h024, v); chk("R7 zero bits leave status", v, 32'h40);

    // R9/R10 masks and interrupt lines
    wr(9'h038, 32'h0000_0040);
    chk("R10 irq1 raised", {31'd0, irqLine1}, 32'h1);
    chk("R10 irq0 quiet", {31'd0, irqLine0}, 32'h0);
    rd(9'h040, v); chk("R9 enable1 readback", v, 32'h40);
    rd(9'h030, v); chk("R8 masked1", v, 32'h40);
    rd(9'h02C, v); chk("R8 masked0", v, 32'h0);
    wr(9'h040, 32'h0000_0040);
    chk("R9 enable clear drops irq1", {31'd0, irqLine1}, 32'h0);
    wr(9'h02C, 32'hFFFF_FFFF);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [31:0] rr, ff, lo, hi, e0, e1, op, np, ex, a, b;
      rr = $urandom; ff = $urandom;
      lo = $urandom & $urandom & $urandom;
      hi = $urandom & $urandom & $urandom;
      e0 = $urandom; e1 = $urandom; np = $urandom; op = pinIn;
      a = $urandom; b = $urandom;
      wr(9'h194, a); wr(9'h190, b);
      outM = (outM | a) & ~b;
      rd(9'h13C, v); chk("R2 random out", v, outM);
      chk("R2 random pinOut", pinOut, outM);
      wr(9'h148, rr); wr(9'h14C, ff); wr(9'h140, lo); wr(9'h144, hi);
      wr(9'h03C, 32'hFFFF_FFFF); wr(9'h034, e0);
      wr(9'h040, 32'hFFFF_FFFF); wr(9'h038, e1);
      wr(9'h02C, 32'hFFFF_FFFF);
      setPins(np);
      ex = lvlOf(op, lo, hi) | lvlOf(np, lo, hi) | edgeOf(op, np, rr, ff);
      rd(9'h024, v); chk("R5 R6 random raw", v, ex);
      rd(9'h02C, v); chk("R8 random masked0", v, ex & e0);
      rd(9'h030, v); chk("R8 random masked1", v, ex & e1);
      chk("R10 random irq0", {31'd0, irqLine0}, {31'd0, |(ex & e0)});
      chk("R10 random irq1", {31'd0, irqLine1}, {31'd0, |(ex & e1)});
      rd(9'h138, v); chk("R4 random input", v, np);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule